// File: doc/BRIEF.md
# Microprogram Sequencer with Shared Address Field

This block is the control half of a microcoded register-transfer system. It holds a small writable control store and a microprogram counter. On every cycle it reads the word at the counter and drives the per-register multiplexer selects and load strobes found in that word. It then either steps the counter by one or jumps. A jump happens only when the word names a condition line and that line is high. Condition line 0 counts as false whatever its value, so a word whose test field is zero always runs in sequence.

One group of bits at the bottom of each word does three jobs. A W-load bit and the test field decide what the group means. It can be the jump target, a constant for the datapath, or the select of the W register's input multiplexer. The bits always reach both the constant output and the W select output unchanged. Only how the rest of the system may use them changes. The W load strobe comes from the W-load bit alone, so W is never loaded while the group holds a constant or a target. A word that sets the W-load bit and also names a condition is malformed. It raises an error flag, loads W, and does not jump.

The store is filled through a synchronous write port, normally while reset is held. All outputs are combinational from the word at the current counter value.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the counter `upc` becomes 0 at that edge.
- R2: A word whose test field (bits [8:6]) is 0 makes the next `upc` equal to `upc`+1. Condition line 0 never causes a jump, whatever the value of `cond[0]`.
- R3: When the W-load bit (bit 9) is 0, the test field is some value t other than 0, and `cond[t]` is 1, the next `upc` is the address field (bits [5:0]). If `cond[t]` is 0, the next `upc` is `upc`+1.
- R4: `const_out` always equals the address field bits [5:0] of the current word, whatever the word's format.
- R5: `w_sel` always equals the address field bits [5:0] of the current word, whatever the word's format.
- R6: `w_clk` equals the W-load bit (bit 9) of the current word. It is therefore low in every word whose address field holds a constant or a jump target.
- R7: A word with the W-load bit at 1 and a test field other than 0 drives `fmt_err` high in the same cycle. It does not jump: the next `upc` is `upc`+1. For every other word `fmt_err` is low.
- R8: For register r, `reg_clk[r]` is word bit 10+r and `reg_mux[2r+1:2r]` is word bits [13+2r:12+2r].
- R9: The increment wraps, so the word at address 63 that does not jump is followed by address 0.
- R10: A word written with `wr_en` high at a rising edge is the one read whenever `upc` later equals `wr_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cond | input | 8 | Condition lines from the datapath; line 0 is ignored |
| wr_en | input | 1 | Control store write strobe |
| wr_addr | input | 6 | Control store write address |
| wr_data | input | 16 | Control store write word |
| upc | output | 6 | Current microprogram counter |
| reg_mux | output | 4 | Input selects of the general registers, 2 bits each |
| reg_clk | output | 2 | Load strobes of the general registers |
| w_clk | output | 1 | Load strobe of register W |
| w_sel | output | 6 | Input select of register W (raw address field) |
| const_out | output | 6 | Constant to the datapath (raw address field) |
| fmt_err | output | 1 | Malformed word: W load combined with a condition test |

## Verification
The control outputs and `fmt_err` are combinational from the word at the current counter. They are due in the same cycle as the `upc` value that selects them. The counter itself moves one rising edge after the word and the condition lines that decide the move. A write lands at the edge where `wr_en` is high. The bench drives inputs on the falling edge and samples one nanosecond later. It compares every output with a behavioural model that holds the model counter of that cycle, and it advances the model only after the comparison, so each check looks at the cycle where the result is due. Short directed programs walk through the jump, malformed-word, W-load and wrap cases in known order. A long run from a pseudo-random store then mixes all word formats under changing condition lines.

// File: rtl/useq_pkg.sv
package useq_pkg;
   typedef enum logic [1:0] {
      FMT_TARGET = 2'd0,
      FMT_CONST  = 2'd1,
      FMT_WSEL   = 2'd2,
      FMT_BAD    = 2'd3
   } useq_fmt_e;

   function automatic useq_fmt_e classify(input logic wload, input logic test_nz);
      if (wload) return test_nz ? FMT_BAD : FMT_WSEL;
      return test_nz ? FMT_TARGET : FMT_CONST;
   endfunction
endpackage

// File: rtl/useq_store.sv
module useq_store #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/useq_cond_sel.sv
module useq_cond_sel #(
   parameter int COND_N = 8,
   parameter int TEST_W = 3
) (
   input  logic [COND_N-1:0] cond,
   input  logic [TEST_W-1:0] test,
   output logic              hit
);
   localparam bit FULL = ((1 << TEST_W) == COND_N);

   logic [COND_N-1:0] masked;
   assign masked = {cond[COND_N-1:1], 1'b0};

   generate
      if (FULL) begin : g_direct
         assign hit = masked[test];
      end else begin : g_scan
         always_comb begin
            hit = 1'b0;
            for (int i = 1; i < COND_N; i++) begin
               if (test == TEST_W'(i)) hit = masked[i];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/useq_decode.sv
module useq_decode
   import useq_pkg::*;
#(
   parameter int UPC_W  = 6,
   parameter int TEST_W = 3,
   parameter int NREG   = 2,
   parameter int MUX_W  = 2,
   parameter int WORD_W = UPC_W + TEST_W + 1 + NREG * (MUX_W + 1)
) (
   input  logic [WORD_W-1:0]     word,
   output logic [UPC_W-1:0]      field,
   output logic [TEST_W-1:0]     test,
   output logic                  wload,
   output logic [NREG-1:0]       reg_clk,
   output logic [NREG*MUX_W-1:0] reg_mux,
   output useq_fmt_e             fmt,
   output logic                  jump_ok
);
   localparam int TEST_LO = UPC_W;
   localparam int WLD_BIT = UPC_W + TEST_W;
   localparam int CK_LO   = WLD_BIT + 1;
   localparam int MX_LO   = CK_LO + NREG;

   assign field = word[UPC_W-1:0];
   assign test  = word[TEST_LO +: TEST_W];
   assign wload = word[WLD_BIT];

   genvar r;
   generate
      for (r = 0; r < NREG; r++) begin : g_reg
         assign reg_clk[r]                 = word[CK_LO + r];
         assign reg_mux[r*MUX_W +: MUX_W]  = word[MX_LO + r*MUX_W +: MUX_W];
      end
   endgenerate

   assign fmt     = classify(wload, |test);
   assign jump_ok = (fmt == FMT_TARGET);
endmodule

// File: rtl/useq_next.sv
module useq_next #(
   parameter int UPC_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             take,
   input  logic [UPC_W-1:0] target,
   output logic [UPC_W-1:0] upc
);
   logic [UPC_W-1:0] inc;
   assign inc = upc + UPC_W'(1);

   always_ff @(posedge clk) begin
      if (rst)       upc <= '0;
      else if (take) upc <= target;
      else           upc <= inc;
   end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
   import useq_pkg::*;
#(
   parameter int UPC_W  = 6,
   parameter int COND_N = 8,
   parameter int NREG   = 2,
   parameter int MUX_W  = 2,
   parameter int TEST_W = (COND_N > 1) ? $clog2(COND_N) : 1,
   parameter int WORD_W = UPC_W + TEST_W + 1 + NREG * (MUX_W + 1)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [COND_N-1:0]     cond,
   input  logic                  wr_en,
   input  logic [UPC_W-1:0]      wr_addr,
   input  logic [WORD_W-1:0]     wr_data,
   output logic [UPC_W-1:0]      upc,
   output logic [NREG*MUX_W-1:0] reg_mux,
   output logic [NREG-1:0]       reg_clk,
   output logic                  w_clk,
   output logic [UPC_W-1:0]      w_sel,
   output logic [UPC_W-1:0]      const_out,
   output logic                  fmt_err
);
   generate
      if (COND_N < 2) begin : g_bad_cond
         $error("useq_sequencer: COND_N must be at least 2");
      end
      if (UPC_W < 1 || UPC_W > 12) begin : g_bad_upc
         $error("useq_sequencer: UPC_W out of range 1..12");
      end
      if (NREG < 1 || MUX_W < 1) begin : g_bad_reg
         $error("useq_sequencer: NREG and MUX_W must be positive");
      end
   endgenerate

   logic [WORD_W-1:0] word;
   logic [UPC_W-1:0]  field;
   logic [TEST_W-1:0] test;
   logic              wload;
   logic              jump_ok;
   logic              hit;
   logic              take;
   useq_fmt_e         fmt;

   useq_store #(.ADDR_W(UPC_W), .DATA_W(WORD_W)) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (upc),
      .rd_data (word)
   );

   useq_decode #(
      .UPC_W(UPC_W), .TEST_W(TEST_W), .NREG(NREG), .MUX_W(MUX_W), .WORD_W(WORD_W)
   ) u_decode (
      .word    (word),
      .field   (field),
      .test    (test),
      .wload   (wload),
      .reg_clk (reg_clk),
      .reg_mux (reg_mux),
      .fmt     (fmt),
      .jump_ok (jump_ok)
   );

   useq_cond_sel #(.COND_N(COND_N), .TEST_W(TEST_W)) u_cond (
      .cond (cond),
      .test (test),
      .hit  (hit)
   );

   assign take = jump_ok & hit;

   useq_next #(.UPC_W(UPC_W)) u_next (
      .clk    (clk),
      .rst    (rst),
      .take   (take),
      .target (field),
      .upc    (upc)
   );

   assign w_clk     = wload;
   assign w_sel     = field;
   assign const_out = field;
   assign fmt_err   = (fmt == FMT_BAD);
endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
   parameter int UPC_W  = 6,
   parameter int COND_N = 8,
   parameter int TEST_W = 3
) (
   input logic              clk,
   input logic              rst,
   input logic [COND_N-1:0] cond,
   input logic [UPC_W-1:0]  upc,
   input logic [UPC_W-1:0]  field,
   input logic [TEST_W-1:0] test,
   input logic              w_clk,
   input logic              fmt_err
);
   assert_reset_zero_R1: assert property (@(posedge clk)
      rst |=> (upc == '0));

   assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
      (test == '0) |=> (upc == UPC_W'($past(upc) + 1'b1)));

   assert_jump_taken_R3: assert property (@(posedge clk) disable iff (rst)
      (!w_clk && test != '0 && cond[test]) |=> (upc == $past(field)));

   assert_wload_guard_R6: assert property (@(posedge clk) disable iff (rst)
      w_clk |-> (test == '0 || fmt_err));

   assert_bad_no_jump_R7: assert property (@(posedge clk) disable iff (rst)
      fmt_err |=> (upc == UPC_W'($past(upc) + 1'b1)));
endmodule

bind useq_sequencer useq_checker #(
   .UPC_W(UPC_W), .COND_N(COND_N), .TEST_W(TEST_W)
) u_useq_checker (
   .clk     (clk),
   .rst     (rst),
   .cond    (cond),
   .upc     (upc),
   .field   (field),
   .test    (test),
   .w_clk   (w_clk),
   .fmt_err (fmt_err)
);

// File: tb/useq_sequencer_bench.sv
`timescale 1ns/1ps
module useq_sequencer_bench;
   localparam int AW = 6;
   localparam int CN = 8;
   localparam int WW = 16;

   logic          clk = 1'b0;
   logic          rst;
   logic [CN-1:0] cond;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [WW-1:0] wr_data;
   logic [AW-1:0] upc;
   logic [3:0]    reg_mux;
   logic [1:0]    reg_clk;
   logic          w_clk;
   logic [AW-1:0] w_sel;
   logic [AW-1:0] const_out;
   logic          fmt_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [WW-1:0] ref_mem [64];
   int            ref_upc = 0;
   int            seen_q[$];

   always #2 clk = ~clk;

   useq_sequencer #(.UPC_W(AW), .COND_N(CN), .NREG(2), .MUX_W(2)) u_useq_sequencer (
      .clk(clk), .rst(rst), .cond(cond), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .upc(upc), .reg_mux(reg_mux), .reg_clk(reg_clk),
      .w_clk(w_clk), .w_sel(w_sel), .const_out(const_out), .fmt_err(fmt_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [WW-1:0] mk(input logic [3:0] mx, input logic [1:0] ck,
                                        input logic wl, input logic [2:0] t,
                                        input logic [5:0] f);
      return {mx, ck, wl, t, f};
   endfunction

   task automatic step(input logic r, input logic [CN-1:0] c, input logic we,
                       input logic [AW-1:0] wa, input logic [WW-1:0] wd, input bit cmp);
      logic [WW-1:0] w;
      logic [5:0] f;
      logic [2:0] t;
      logic wl;
      @(negedge clk);
      rst = r; cond = c; wr_en = we; wr_addr = wa; wr_data = wd;
      #1;
      if (cmp) begin
         w  = ref_mem[ref_upc];
         f  = w[5:0];
         t  = w[8:6];
         wl = w[9];
         seen_q.push_back(int'(upc));
         chk("R2/R3 upc", 32'(upc), 32'(ref_upc));
         chk("R4 const_out", 32'(const_out), 32'(f));
         chk("R5 w_sel", 32'(w_sel), 32'(f));
         chk("R6 w_clk", 32'(w_clk), 32'(wl));
         chk("R7 fmt_err", 32'(fmt_err), 32'(wl && t != 3'd0));
         chk("R8 reg_clk", 32'(reg_clk), 32'(w[11:10]));
         chk("R8 reg_mux", 32'(reg_mux), 32'(w[15:12]));
         if (r) ref_upc = 0;
         else if (!wl && t != 3'd0 && c[t]) ref_upc = int'(f);
         else ref_upc = (ref_upc + 1) % 64;
      end else begin
         ref_upc = 0;
      end
      if (we) ref_mem[wa] = wd;
   endtask

   task automatic expect_path(input string tag, input int exp[]);
      foreach (exp[i]) begin
         chk(tag, 32'(seen_q[i]), 32'(exp[i]));
      end
      seen_q.delete();
   endtask

   initial begin
      rst = 1'b1; cond = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      step(1'b1, '0, 1'b0, '0, '0, 1'b0);
      // R10: store loaded through the write port while reset holds
      for (int a = 0; a < 64; a++) begin
         logic [WW-1:0] d;
         case (a)
            0:  d = mk(4'h9, 2'b11, 1'b0, 3'd0, 6'h2A);
            1:  d = mk(4'h6, 2'b01, 1'b1, 3'd5, 6'h05);
            2:  d = mk(4'h0, 2'b00, 1'b0, 3'd3, 6'd62);
            62: d = mk(4'h3, 2'b10, 1'b1, 3'd0, 6'd17);
            63: d = mk(4'hC, 2'b00, 1'b0, 3'd0, 6'h09);
            default: d = mk(4'(a), 2'(a), 1'b0, 3'd0, 6'(a));
         endcase
         step(1'b1, '0, 1'b1, 6'(a), d, 1'b1);
      end
      // R1: counter at zero after reset
      chk("R1 reset upc", 32'(upc), 32'd0);
      seen_q.delete();
      // all lines high: line 0 ignored (R2), malformed word no jump (R7), jump (R3), wrap (R9)
      for (int k = 0; k < 6; k++) step(1'b0, 8'hFF, 1'b0, '0, '0, 1'b1);
      expect_path("R2/R7/R3/R9 path", '{0, 1, 2, 62, 63, 0});
      // all lines low: the word at 2 falls through (R3)
      for (int k = 0; k < 4; k++) step(1'b0, 8'h00, 1'b0, '0, '0, 1'b1);
      expect_path("R3 not taken", '{1, 2, 3, 4});
      // R1: reset mid-run returns the counter to zero
      step(1'b1, 8'h00, 1'b0, '0, '0, 1'b1);
      step(1'b0, 8'h00, 1'b0, '0, '0, 1'b1);
      chk("R1 reset mid-run", 32'(seen_q[1]), 32'd0);
      seen_q.delete();
      // R10: reload with pseudo-random words under reset, then free run
      for (int a = 0; a < 64; a++) begin
         step(1'b1, 8'h00, 1'b1, 6'(a), WW'($urandom), 1'b1);
      end
      for (int k = 0; k < 3000; k++) begin
         step(1'b0, CN'($urandom), 1'b0, '0, '0, 1'b1);
      end
      seen_q.delete();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule